// File: doc/BRIEF.md
# Operand Specifier Address Unit

This block resolves one operand specifier per start pulse. From a 3-bit addressing-mode code, a base register number, an index register number, a 32-bit literal/displacement field and a 2-bit datum-size code, it produces one of two things. It gives either the operand value itself, or the effective address of an operand held in memory. A flag tells the consumer which of the two it is. The block reads two registers of an external 16-entry, 32-bit general-purpose register file through combinational read ports. In the stepping modes it also returns the stepped base register through a one-cycle write-back port, which the register file applies.

Pushes and pops on the stack need no mode of their own. A push is an auto-decrement specifier naming register 14 as the base. A pop is an auto-increment specifier naming the same register. Memory access, instruction-stream parsing and condition codes belong to neighbouring blocks.

Top module: `opspec_unit`

## Requirements
- R1: Mode code 0 (register) returns the contents of the base register, with the memory flag low.
- R2: Mode code 1 (literal) returns the 32-bit field unchanged, with the memory flag low.
- R3: Mode code 2 (register-deferred) returns the base register contents as an address, with the memory flag high.
- R4: Mode code 3 (displacement) returns base register plus field as an address, with the memory flag high.
- R5: Mode code 6 (indexed) returns (base register + field) + (index register × d) as an address, with the memory flag high. The scaled index is the index register shifted left by the size code.
- R6: Mode code 4 (post-increment) returns the base register's old value as an address, and writes old value + d back to the base register number.
- R7: Mode code 5 (pre-decrement) returns old value − d as an address, and writes the same value back to the base register number. With base register 14, R6 and R7 act as pop and push.
- R8: Size code 0, 1, 2 and 3 give d = 1, 2, 4 and 8 bytes respectively.
- R9: Valid rises exactly one cycle after a start pulse, for one cycle. Write-back enable is high only in that cycle and only for mode codes 4 and 5.
- R10: Mode code 7 is reserved. It sets the illegal flag with valid, keeps write-back and memory flag low, and the result is 0.
- R11: While reset is asserted, valid, write-back enable, memory flag, illegal flag and all data outputs are 0.
- R12: All address and step arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Resolve the specifier presented this cycle |
| mode_i | input | 3 | Addressing-mode code |
| base_reg_i | input | 4 | Base register number |
| index_reg_i | input | 4 | Index register number (indexed mode) |
| field_i | input | 32 | Literal or displacement field |
| size_i | input | 2 | Datum size code |
| base_raddr_o | output | 4 | Register file read address, base |
| base_rdata_i | input | 32 | Register file read data, base |
| index_raddr_o | output | 4 | Register file read address, index |
| index_rdata_i | input | 32 | Register file read data, index |
| valid_o | output | 1 | Result valid (one cycle) |
| result_o | output | 32 | Operand value or effective address |
| mem_o | output | 1 | Result is an address; memory must be accessed |
| illegal_o | output | 1 | Reserved mode code seen |
| wb_en_o | output | 1 | Register write-back enable |
| wb_reg_o | output | 4 | Register number to write |
| wb_data_o | output | 32 | Stepped register value |

## Verification
The assertions assume that the register file returns the addressed contents combinationally in the start cycle. They also assume that a write-back lands before any later specifier reads the same register. The stimulus keeps to this by leaving an idle cycle after each start, and by modelling the register file so that it applies each write-back at the clock edge that ends the write-back cycle. Start is never held for two cycles in a row, so every result pulse maps to exactly one issued specifier.

// File: rtl/opspec_pkg.sv
package opspec_pkg;
  typedef enum logic [2:0] {
    M_REG   = 3'd0,
    M_LIT   = 3'd1,
    M_DEFER = 3'd2,
    M_DISP  = 3'd3,
    M_POST  = 3'd4,
    M_PRE   = 3'd5,
    M_INDEX = 3'd6,
    M_RSVD  = 3'd7
  } spec_mode_e;

  typedef struct packed {
    logic use_base;
    logic use_field;
    logic use_index;
    logic step_up;
    logic step_dn;
    logic mem;
    logic illegal;
  } spec_ctl_t;
endpackage

// File: rtl/opspec_decode.sv
module opspec_decode
  import opspec_pkg::*;
(
  input  logic [2:0] mode_i,
  output spec_ctl_t  ctl_o
);
  always_comb begin
    ctl_o = '0;
    unique case (spec_mode_e'(mode_i))
      M_REG:   ctl_o.use_base = 1'b1;
      M_LIT:   ctl_o.use_field = 1'b1;
      M_DEFER: begin ctl_o.use_base = 1'b1; ctl_o.mem = 1'b1; end
      M_DISP:  begin ctl_o.use_base = 1'b1; ctl_o.use_field = 1'b1; ctl_o.mem = 1'b1; end
      M_POST:  begin ctl_o.use_base = 1'b1; ctl_o.step_up = 1'b1; ctl_o.mem = 1'b1; end
      M_PRE:   begin ctl_o.use_base = 1'b1; ctl_o.step_dn = 1'b1; ctl_o.mem = 1'b1; end
      M_INDEX: begin
        ctl_o.use_base  = 1'b1;
        ctl_o.use_field = 1'b1;
        ctl_o.use_index = 1'b1;
        ctl_o.mem       = 1'b1;
      end
      default: ctl_o.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/opspec_scale.sv
module opspec_scale #(
  parameter int XLEN   = 32,
  parameter int SZ_W   = 2
) (
  input  logic [SZ_W-1:0] size_i,
  input  logic [XLEN-1:0] index_i,
  output logic [XLEN-1:0] step_o,
  output logic [XLEN-1:0] scaled_o
);
  localparam int NSIZE = 1 << SZ_W;

  // one-hot step and shifted index built per size code
  logic [NSIZE-1:0][XLEN-1:0] step_tab;
  logic [NSIZE-1:0][XLEN-1:0] shift_tab;

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    assign step_tab[s]  = XLEN'(1) << s;
    assign shift_tab[s] = index_i << s;
  end

  assign step_o   = step_tab[size_i];
  assign scaled_o = shift_tab[size_i];
endmodule

// File: rtl/opspec_agen.sv
module opspec_agen
  import opspec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  spec_ctl_t       ctl_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] field_i,
  input  logic [XLEN-1:0] scaled_i,
  input  logic [XLEN-1:0] step_i,
  output logic [XLEN-1:0] result_o,
  output logic [XLEN-1:0] wb_data_o
);
  logic [XLEN-1:0] base_term, field_term, index_term, stepped;

  assign base_term  = ctl_i.use_base  ? base_i   : '0;
  assign field_term = ctl_i.use_field ? field_i  : '0;
  assign index_term = ctl_i.use_index ? scaled_i : '0;
  assign stepped    = ctl_i.step_dn ? (base_i - step_i) : (base_i + step_i);

  always_comb begin
    if (ctl_i.illegal)      result_o = '0;
    else if (ctl_i.step_dn) result_o = stepped;
    else                    result_o = base_term + field_term + index_term;
  end

  assign wb_data_o = (ctl_i.step_up || ctl_i.step_dn) ? stepped : '0;
endmodule

// File: rtl/opspec_unit.sv
module opspec_unit
  import opspec_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  parameter int SZ_W = 2,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [2:0]      mode_i,
  input  logic [RW-1:0]   base_reg_i,
  input  logic [RW-1:0]   index_reg_i,
  input  logic [XLEN-1:0] field_i,
  input  logic [SZ_W-1:0] size_i,
  output logic [RW-1:0]   base_raddr_o,
  input  logic [XLEN-1:0] base_rdata_i,
  output logic [RW-1:0]   index_raddr_o,
  input  logic [XLEN-1:0] index_rdata_i,
  output logic            valid_o,
  output logic [XLEN-1:0] result_o,
  output logic            mem_o,
  output logic            illegal_o,
  output logic            wb_en_o,
  output logic [RW-1:0]   wb_reg_o,
  output logic [XLEN-1:0] wb_data_o
);
  spec_ctl_t       ctl;
  logic [XLEN-1:0] step, scaled, res_d, wb_d;
  logic [2:0]      mode_q;
  logic [SZ_W-1:0] size_q;

  assign base_raddr_o  = base_reg_i;
  assign index_raddr_o = index_reg_i;

  opspec_decode u_dec (.mode_i(mode_i), .ctl_o(ctl));

  opspec_scale #(.XLEN(XLEN), .SZ_W(SZ_W)) u_scale (
    .size_i(size_i), .index_i(index_rdata_i), .step_o(step), .scaled_o(scaled)
  );

  opspec_agen #(.XLEN(XLEN)) u_agen (
    .ctl_i(ctl), .base_i(base_rdata_i), .field_i(field_i), .scaled_i(scaled),
    .step_i(step), .result_o(res_d), .wb_data_o(wb_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      mem_o     <= 1'b0;
      illegal_o <= 1'b0;
      wb_en_o   <= 1'b0;
      wb_reg_o  <= '0;
      wb_data_o <= '0;
      mode_q    <= '0;
      size_q    <= '0;
    end else begin
      valid_o   <= start_i;
      wb_en_o   <= start_i && (ctl.step_up || ctl.step_dn);
      if (start_i) begin
        result_o  <= res_d;
        mem_o     <= ctl.mem;
        illegal_o <= ctl.illegal;
        wb_reg_o  <= base_reg_i;
        wb_data_o <= wb_d;
        mode_q    <= mode_i;
        size_q    <= size_i;
      end else begin
        mem_o     <= 1'b0;
        illegal_o <= 1'b0;
      end
    end
  end

  // Checks
  assert_valid_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  assert_valid_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);
  assert_wb_only_auto_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> valid_o && (mode_q == M_POST || mode_q == M_PRE));
  assert_rsvd_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> valid_o && !mem_o && !wb_en_o && result_o == '0);
  assert_pre_dec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_en_o && mode_q == M_PRE) |-> wb_data_o == result_o);
  assert_post_inc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_en_o && mode_q == M_POST) |-> wb_data_o == result_o + (XLEN'(1) << size_q));
  assert_flags_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_o, illegal_o}));
endmodule

// File: tb/opspec_unit_test.sv
module opspec_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [3:0]  breg = '0, ireg = '0;
  logic [31:0] field = '0;
  logic [1:0]  size = '0;
  logic [3:0]  b_ra, i_ra;
  logic [31:0] b_rd, i_rd;
  logic        valid, mem, ill, wb_en;
  logic [31:0] result, wb_data;
  logic [3:0]  wb_reg;

  logic [31:0] rf [16];
  logic [31:0] exp_rf [16];

  typedef struct {
    logic [31:0] res;
    logic        mem;
    logic        ill;
    logic        wb;
    logic [3:0]  wreg;
    logic [31:0] wdata;
    string       tag;
  } item_t;
  item_t q[$];

  int compared = 0, mismatched = 0;

  always #10 clk = ~clk;

  assign b_rd = rf[b_ra];
  assign i_rd = rf[i_ra];

  always @(posedge clk) if (wb_en) rf[wb_reg] <= wb_data;

  opspec_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .base_reg_i(breg), .index_reg_i(ireg), .field_i(field), .size_i(size),
    .base_raddr_o(b_ra), .base_rdata_i(b_rd), .index_raddr_o(i_ra), .index_rdata_i(i_rd),
    .valid_o(valid), .result_o(result), .mem_o(mem), .illegal_o(ill),
    .wb_en_o(wb_en), .wb_reg_o(wb_reg), .wb_data_o(wb_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] m, input logic [3:0] b, input logic [3:0] x,
                       input logic [31:0] f, input logic [1:0] s, input string tag);
    item_t it;
    logic [31:0] d, bv;
    d = 32'd1 << s;
    bv = exp_rf[b];
    it.mem = 1'b0; it.ill = 1'b0; it.wb = 1'b0; it.wreg = b; it.wdata = '0; it.tag = tag;
    case (m)
      3'd0: it.res = bv;
      3'd1: it.res = f;
      3'd2: begin it.res = bv; it.mem = 1'b1; end
      3'd3: begin it.res = bv + f; it.mem = 1'b1; end
      3'd4: begin it.res = bv; it.mem = 1'b1; it.wb = 1'b1; it.wdata = bv + d; end
      3'd5: begin it.res = bv - d; it.mem = 1'b1; it.wb = 1'b1; it.wdata = bv - d; end
      3'd6: begin it.res = bv + f + exp_rf[x] * d; it.mem = 1'b1; end
      default: begin it.res = '0; it.ill = 1'b1; end
    endcase
    if (it.wb) exp_rf[b] = it.wdata;
    @(negedge clk);
    mode = m; breg = b; ireg = x; field = f; size = s; start = 1'b1;
    q.push_back(it);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R9 unexpected valid", 32'd1, 32'd0);
      end else begin
        item_t e;
        e = q.pop_front();
        check(result == e.res, {e.tag, " result"}, result, e.res);
        check(mem == e.mem, {e.tag, " mem flag"}, 32'(mem), 32'(e.mem));
        check(ill == e.ill, {e.tag, " R10 illegal flag"}, 32'(ill), 32'(e.ill));
        check(wb_en == e.wb, {e.tag, " R9 wb enable"}, 32'(wb_en), 32'(e.wb));
        if (e.wb) begin
          check(wb_reg == e.wreg, {e.tag, " wb reg"}, 32'(wb_reg), 32'(e.wreg));
          check(wb_data == e.wdata, {e.tag, " wb data"}, wb_data, e.wdata);
        end
      end
    end else if (rst_n && wb_en) begin
      check(1'b0, "R9 stray write-back", 32'd1, 32'd0);
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      rf[i] = 32'h1000_0000 + 32'(i) * 32'h111;
      exp_rf[i] = rf[i];
    end
    rf[14] = 32'h0000_2000; exp_rf[14] = rf[14];
    rf[3] = 32'd5; exp_rf[3] = 32'd5;
    rf[7] = 32'd0; exp_rf[7] = 32'd0;
    rf[9] = 32'hFFFF_FFFC; exp_rf[9] = rf[9];

    repeat (3) @(negedge clk);
    // R11 reset state
    check({valid, mem, ill, wb_en} == 4'b0 && result == 0 && wb_data == 0 && wb_reg == 0,
          "R11 reset outputs", {valid, mem, ill, wb_en, result[27:0]}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    issue(3'd0, 4'd2, 4'd0, 32'hDEAD_BEEF, 2'd0, "R1 register");
    issue(3'd0, 4'd14, 4'd0, 32'h0, 2'd3, "R1 register r14");
    issue(3'd1, 4'd2, 4'd0, 32'hCAFE_F00D, 2'd1, "R2 literal");
    issue(3'd1, 4'd0, 4'd0, 32'h0000_0000, 2'd2, "R2 literal zero");
    issue(3'd2, 4'd5, 4'd0, 32'h1234, 2'd2, "R3 deferred");
    issue(3'd3, 4'd6, 4'd0, 32'h0000_0040, 2'd2, "R4 displacement");
    issue(3'd3, 4'd6, 4'd0, 32'hFFFF_FFF0, 2'd0, "R4 negative displacement");
    for (int s = 0; s < 4; s++) begin
      issue(3'd6, 4'd1, 4'd3, 32'h100, 2'(s), "R5 R8 indexed size");
    end
    issue(3'd4, 4'd4, 4'd0, 32'h0, 2'd0, "R6 R8 post-inc byte");
    issue(3'd4, 4'd4, 4'd0, 32'h0, 2'd1, "R6 R8 post-inc word");
    issue(3'd0, 4'd4, 4'd0, 32'h0, 2'd0, "R6 register after post-inc");
    issue(3'd5, 4'd14, 4'd0, 32'h0, 2'd2, "R7 push");
    issue(3'd5, 4'd14, 4'd0, 32'h0, 2'd3, "R7 R8 push quad");
    issue(3'd4, 4'd14, 4'd0, 32'h0, 2'd3, "R6 pop quad");
    issue(3'd4, 4'd14, 4'd0, 32'h0, 2'd2, "R6 pop");
    issue(3'd5, 4'd7, 4'd0, 32'h0, 2'd3, "R12 pre-dec wrap");
    issue(3'd4, 4'd9, 4'd0, 32'h0, 2'd3, "R12 post-inc wrap");
    issue(3'd7, 4'd5, 4'd0, 32'h5555, 2'd1, "R10 reserved");
    issue(3'd0, 4'd5, 4'd0, 32'h0, 2'd0, "R10 base untouched");
    issue(3'd2, 4'd14, 4'd0, 32'h0, 2'd0, "R3 deferred r14");

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R9 missing results", 32'(q.size()), 32'd0);
    for (int i = 0; i < 16; i++) begin
      check(rf[i] == exp_rf[i], "R6 R7 register file after write-backs", rf[i], exp_rf[i]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule